// File: doc/BRIEF.md
# Grouped Multiplicity Trigger

This block watches a 36-bit vector of tile-over-threshold flags that arrives fresh on every clock. It counts how many flags are set, either over the whole array or within fixed groups, and compares each count against a programmable threshold. The result is a 4-bit registered trigger vector that a downstream link serializes.

A 2-bit mode selects how the flags are grouped. In global mode one count over all 36 flags is compared to a 6-bit threshold, which gives a minimum-activity trigger. In coincidence mode the array splits into a low and a high half of 18 flags. Each half is compared to its own 3-bit threshold and the two results are ANDed. Dual mode uses the same halves but reports them as two separate bits. Quad mode splits the array into four quarters of 9 flags, each with a 1-bit threshold, and reports four bits.

The mode and thresholds are loaded through a single-cycle write port. A group fires when its count is greater than or equal to its threshold.

Top module: `mult_trig`

## Requirements
- R1: While rst_ni is low, trig_o is 0, the mode is global (0) and every threshold is 0. With all flags clear, the first trigger after reset is therefore 4'b0001.
- R2: A flag vector presented at a rising clock edge is reflected in trig_o after the following rising edge, so the latency is two edges. A configuration write accepted at the same edge as a flag vector already applies to that vector.
- R3: In mode 0, trig_o[0] is 1 exactly when the number of set flags among all 36 is greater than or equal to the 6-bit global threshold.
- R4: In mode 1, trig_o[0] is the AND of two tests: the count of flags[17:0] is at least the low-half threshold, and the count of flags[35:18] is at least the high-half threshold. Both thresholds are 3 bits wide.
- R5: In mode 2, trig_o[0] carries the low-half test and trig_o[1] carries the high-half test. Both use the same halves and 3-bit thresholds as in mode 1.
- R6: In mode 3, trig_o[i] is 1 when quarter i contains at least as many set flags as its 1-bit threshold. The quarters are flags[8:0], [17:9], [26:18] and [35:27] for i = 0 to 3.
- R7: A threshold of 0 makes its group fire whatever the flags are. A threshold above the group's size keeps it from firing.
- R8: trig_o[3:1] is 0 in modes 0 and 1, and trig_o[3:2] is 0 in mode 2.
- R9: When wr_en_i is high, the write lands at the clock edge. Address 0 takes the mode from wr_data_i[1:0], address 1 the global threshold from wr_data_i[5:0], and addresses 2 and 3 the low and high half thresholds from wr_data_i[2:0]. Addresses 4 to 7 take quarter 0 to 3 thresholds from wr_data_i[0]. Data bits above a field's width are dropped, and with wr_en_i low the configuration holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 36 | Tile-over-threshold flags, sampled every clock |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Configuration register address |
| wr_data_i | input | 6 | Configuration write data |
| trig_o | output | 4 | Registered trigger bits |

## Verification
Every trigger bit depends on two registers: the flag capture and the output register. The bench therefore drives flags and writes at the falling edge and pushes the expected vector for that sample onto a queue. It then compares trig_o with the entry pushed two falling edges earlier, so each result is sampled half a clock after the second rising edge. A write is applied to the bench's configuration copy in the same step as the flags it accompanies, which checks that the new setting already governs that sample.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned N_FLAGS = 36;
  localparam int unsigned GTHR_W  = 6;
  localparam int unsigned HTHR_W  = 3;
  localparam int unsigned QTHR_W  = 1;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 6;
  localparam int unsigned OUT_W   = 4;

  typedef enum logic [1:0] {
    MODE_GLOBAL = 2'd0,
    MODE_COINC  = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_QUAD   = 2'd3
  } mode_e;

  // register addresses
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_GTHR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HTHR0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_QTHR0 = 3'd4;
endpackage

// File: rtl/mt_popcount.sv
module mt_popcount #(
  parameter int unsigned W  = 9,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/mt_grp_cmp.sv
module mt_grp_cmp #(
  parameter int unsigned W  = 18,
  parameter int unsigned TW = 3
) (
  input  logic [W-1:0]  bits_i,
  input  logic [TW-1:0] thr_i,
  output logic          hit_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned MW = (CW > TW) ? CW : TW;

  logic [CW-1:0] cnt;

  mt_popcount #(.W(W)) u_cnt (
    .bits_i (bits_i),
    .cnt_o  (cnt)
  );

  assign hit_o = (MW'(cnt) >= MW'(thr_i));
endmodule

// File: rtl/mt_cfg_regs.sv
module mt_cfg_regs
  import mt_pkg::*;
#(
  parameter int unsigned GW = GTHR_W,
  parameter int unsigned HW = HTHR_W,
  parameter int unsigned QW = QTHR_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  output mode_e              mode_o,
  output logic [GW-1:0]      thr_g_o,
  output logic [1:0][HW-1:0] thr_h_o,
  output logic [3:0][QW-1:0] thr_q_o
);
  mode_e mode_q;
  logic [GW-1:0] thr_g_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_GLOBAL;
      thr_g_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_MODE) mode_q  <= mode_e'(wr_data_i[1:0]);
      if (wr_addr_i == A_GTHR) thr_g_q <= wr_data_i[GW-1:0];
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_h_o[h] <= '0;
      else if (wr_en_i && wr_addr_i == A_HTHR0 + AW'(h)) thr_h_o[h] <= wr_data_i[HW-1:0];
    end
  end

  for (genvar q = 0; q < 4; q++) begin : g_quar
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_q_o[q] <= '0;
      else if (wr_en_i && wr_addr_i == A_QTHR0 + AW'(q)) thr_q_o[q] <= wr_data_i[QW-1:0];
    end
  end

  assign mode_o  = mode_q;
  assign thr_g_o = thr_g_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mode_o) && $stable(thr_g_o)); // R9
endmodule

// File: rtl/mult_trig.sv
module mult_trig
  import mt_pkg::*;
#(
  parameter int unsigned NF = N_FLAGS,
  parameter int unsigned GW = GTHR_W,
  parameter int unsigned HW = HTHR_W,
  parameter int unsigned QW = QTHR_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OUT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] flags_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [OW-1:0] trig_o
);
  localparam int unsigned HALF = NF / 2;
  localparam int unsigned QUAR = NF / 4;

  mode_e              mode;
  logic [GW-1:0]      thr_g;
  logic [1:0][HW-1:0] thr_h;
  logic [3:0][QW-1:0] thr_q;

  logic [NF-1:0] flag_q;
  logic          glob_hit;
  logic [1:0]    half_hit;
  logic [3:0]    quar_hit;
  logic [OW-1:0] trig_d, trig_q;

  mt_cfg_regs #(.GW(GW), .HW(HW), .QW(QW), .AW(AW), .DW(DW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode),
    .thr_g_o   (thr_g),
    .thr_h_o   (thr_h),
    .thr_q_o   (thr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flags_i;
  end

  mt_grp_cmp #(.W(NF), .TW(GW)) u_glob (
    .bits_i (flag_q),
    .thr_i  (thr_g),
    .hit_o  (glob_hit)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    mt_grp_cmp #(.W(HALF), .TW(HW)) u_cmp (
      .bits_i (flag_q[h*HALF +: HALF]),
      .thr_i  (thr_h[h]),
      .hit_o  (half_hit[h])
    );
  end

  for (genvar q = 0; q < 4; q++) begin : g_quar
    mt_grp_cmp #(.W(QUAR), .TW(QW)) u_cmp (
      .bits_i (flag_q[q*QUAR +: QUAR]),
      .thr_i  (thr_q[q]),
      .hit_o  (quar_hit[q])
    );
  end

  always_comb begin
    trig_d = '0;
    unique case (mode)
      MODE_GLOBAL: trig_d[0]   = glob_hit;
      MODE_COINC:  trig_d[0]   = half_hit[0] & half_hit[1];
      MODE_DUAL:   trig_d[1:0] = half_hit;
      MODE_QUAD:   trig_d[3:0] = quar_hit;
      default:     trig_d      = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_d;
  end

  assign trig_o = trig_q;

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GLOBAL || mode == MODE_COINC) |=> trig_o[3:1] == 3'b000); // R8
  AST_COINC_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_COINC) |=> trig_o[0] == $past(half_hit[0] && half_hit[1])); // R4
  AST_DUAL_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_DUAL) |=> trig_o == {2'b00, $past(half_hit)}); // R5
  AST_GTHR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GLOBAL && thr_g == '0) |=> trig_o[0]); // R7
  AST_QTHR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_QUAD && thr_q[3] == '0) |=> trig_o[3]); // R7
endmodule

// File: tb/sim_mult_trig.sv
module sim_mult_trig;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] flags = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [5:0]  data = '0;
  logic [3:0]  trig;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // bench copy of the configuration
  int m_mode = 0, m_tg = 0;
  int m_th[2] = '{0, 0};
  int m_tq[4] = '{0, 0, 0, 0};
  logic [3:0] expq[$];

  always #10 clk = ~clk;

  mult_trig u0 (
    .clk_i(clk), .rst_ni(rst_n), .flags_i(flags),
    .wr_en_i(we), .wr_addr_i(addr), .wr_data_i(data), .trig_o(trig)
  );

  function automatic int cnt(logic [35:0] f, int lo, int hi);
    int c = 0;
    for (int i = lo; i <= hi; i++) if (f[i]) c++;
    return c;
  endfunction

  function automatic logic [3:0] model(logic [35:0] f);
    logic [3:0] r = '0;
    case (m_mode)
      0: r[0] = cnt(f, 0, 35) >= m_tg;
      1: r[0] = (cnt(f, 0, 17) >= m_th[0]) && (cnt(f, 18, 35) >= m_th[1]);
      2: begin r[0] = cnt(f, 0, 17) >= m_th[0]; r[1] = cnt(f, 18, 35) >= m_th[1]; end
      default: for (int q = 0; q < 4; q++) r[q] = cnt(f, 9*q, 9*q+8) >= m_tq[q];
    endcase
    return r;
  endfunction

  task automatic check(logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: trig_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: check the result due now (R2 latency), then drive the next sample
  task automatic step(logic [35:0] f, bit w = 0, int a = 0, int d = 0);
    @(negedge clk);
    if (expq.size() == 2) check(trig, expq.pop_front());
    flags = f; we = w; addr = 3'(a); data = 6'(d);
    if (w) begin
      case (a)
        0: m_mode = d & 3;
        1: m_tg = d & 63;
        2, 3: m_th[a-2] = d & 7;
        default: m_tq[a-4] = d & 1;
      endcase
    end
    expq.push_back(model(f));
  endtask

  function automatic logic [35:0] nbits(int lo, int n);
    logic [35:0] v = '0;
    for (int i = 0; i < n; i++) v[lo+i] = 1'b1;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; check(trig, 4'b0000);
    rst_n = 1'b1;
    expq.push_back(4'b0001); // flag register cleared, global threshold 0
    tag = "R1"; step('0); step('0);

    tag = "R3"; step('0, 1, 1, 5);
    step(nbits(0, 4)); step(nbits(0, 5)); step(nbits(30, 6));
    step(36'hFFFFFFFFF); step(36'h0); step(nbits(10, 5));
    tag = "R7"; step(36'hFFFFFFFFF, 1, 1, 63); step(36'hFFFFFFFFF);
    tag = "R7"; step(36'h0, 1, 1, 0); step(36'h0);

    tag = "R2"; step('0, 1, 1, 1); step(36'h1); step('0); step('0); step(36'h800000000); step('0);

    tag = "R9"; step('0, 1, 2, 6'h3F); step('0, 1, 3, 6'h0A);
    tag = "R4"; step(nbits(0, 7), 1, 0, 1);
    step(nbits(0, 7) | nbits(18, 1)); step(nbits(0, 7) | nbits(20, 2));
    step(nbits(0, 18)); step(nbits(0, 6) | nbits(18, 18)); step(36'hFFFFFFFFF);
    tag = "R8"; step(36'hFFFFFFFFF); step('0);

    tag = "R5"; step(nbits(0, 7), 1, 0, 2);
    step(nbits(18, 2)); step(nbits(0, 7) | nbits(18, 2)); step(nbits(3, 7));
    tag = "R9"; step('0, 1, 3, 6'h3C); step(36'h0); step(nbits(25, 4));

    tag = "R6"; step(36'h0, 1, 0, 3);
    step('0, 1, 4, 1); step('0, 1, 5, 1); step('0, 1, 6, 1); step('0, 1, 7, 6'h3F);
    step(nbits(0, 1)); step(nbits(9, 1)); step(nbits(18, 1)); step(nbits(27, 1));
    step(nbits(8, 2)); step(nbits(17, 2)); step(nbits(26, 2));
    tag = "R7"; step('0, 1, 5, 6'h3E); step('0); step(nbits(0, 9));

    tag = "R9"; step(36'hFFFFFFFFF); step('0, 0, 0, 0); step(36'hFFFFFFFFF, 0, 7, 0);

    tag = "R2"; step(36'h0, 1, 0, 0); step(36'h0, 1, 1, 36); step(36'hFFFFFFFFF); step(nbits(1, 35));

    tag = "R3";
    for (int k = 0; k < 400; k++) begin
      logic [35:0] f;
      f = {$urandom, $urandom};
      if ((k % 37) == 0) step(f, 1, $urandom_range(0, 7), $urandom_range(0, 63));
      else step(f);
      if ((k % 37) == 0) tag = "R9"; else tag = "R3";
    end
    step('0); step('0); step('0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule